// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides whether a CAN frame that has just been received should be stored in a receive FIFO. It takes the frame's 29-bit identifier field and its extended-format and remote-request flags. It compares them against a small table of 32-bit filter words. A format select sets how each word is read: as one full identifier, as two 14-bit partial identifiers, or as four 8-bit identifier prefixes. The table is searched from the lowest sub-entry number upward, and the first hit is reported.

A frame is offered with a one-cycle strobe. The accept flag and the number of the matching sub-entry appear on registered outputs exactly one clock later. The filter table is loaded through a plain write port, and that port only takes effect while the freeze input is high, so the table cannot change under live traffic. Standard identifiers are supplied left-aligned in the 29-bit field: the 11-bit standard ID occupies `frame_id[28:18]`.

Top module: `can_rx_id_filter`

## Requirements
- R1: With `fmt_sel`=2'b00, a standard frame (`frame_ide`=0) matches a word when word bit 31 equals `frame_rtr`, bit 30 is 0 and word bits [28:18] equal `frame_id[28:18]`. `frame_id[17:0]` has no effect.
- R2: With `fmt_sel`=2'b00, an extended frame (`frame_ide`=1) matches a word only when word bit 31 equals `frame_rtr`, bit 30 is 1 and word bits [28:0] equal all 29 bits of `frame_id`.
- R3: In formats 2'b00 and 2'b01, a frame whose remote flag or extended flag differs from the entry's remote bit or extended bit never matches that entry, even when the identifier bits agree.
- R4: With `fmt_sel`=2'b01, each word holds two 16-bit halves. Sub-entry 0 is bits [31:16] and sub-entry 1 is bits [15:0]. Within a half, bit 15 is the remote bit, bit 14 is the extended bit and bits [13:0] are the ID. A standard frame matches when half bits [13:3] equal `frame_id[28:18]`.
- R5: With `fmt_sel`=2'b01, an extended frame matches a half when half bits [13:0] equal `frame_id[28:15]`. `frame_id[14:0]` has no effect.
- R6: With `fmt_sel`=2'b10, each word holds four bytes, and sub-entry s is bits [31-8s:24-8s]. A byte matches any frame, of any type, whose `frame_id[28:21]` equals it.
- R7: With `fmt_sel`=2'b11, no frame is accepted.
- R8: The reported index is the element number in format 2'b00, 2×element+half in format 2'b01 and 4×element+byte in format 2'b10. When several sub-entries match, the lowest index is reported.
- R9: Table writes take effect only while `freeze` is 1. A write made while `freeze` is 0 leaves the table unchanged.
- R10: `acc_hit` and `acc_idx` are 0 after reset and are updated one clock after `frame_vld`. They are 0 in every cycle that does not follow a strobe, and also after a strobe that found no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze | input | 1 | Table write enable qualifier |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 3 | Filter element number to write |
| wr_data | input | 32 | Filter word |
| fmt_sel | input | 2 | Element format: 00 one ID, 01 two IDs, 10 four prefixes, 11 reject all |
| frame_vld | input | 1 | Frame-valid strobe, one cycle |
| frame_id | input | 29 | Received identifier, standard IDs in bits [28:18] |
| frame_ide | input | 1 | Frame uses extended format |
| frame_rtr | input | 1 | Frame is a remote request |
| acc_hit | output | 1 | Frame accepted |
| acc_idx | output | 5 | Lowest matching sub-entry number |

## Verification
Each format is swept over several tables of pseudo-random filter words. For every sub-entry, the bench offers a frame built to match it, then versions with the extended flag inverted, the remote flag inverted, or one identifier bit flipped. These variants separate qualifier checking from identifier comparison, and the random low bits show whether the bits that should be ignored really are ignored. Tables with duplicate entries and bytes test the lowest-index rule. Writes made without freeze are mixed into every round, so that a table that leaks those writes shows up as wrong accept decisions.

// File: rtl/can_filt_pkg.sv
// Package: shared widths, field positions and types for the receive
// identifier acceptance filter. Assumes the 32-bit filter word and the
// left-aligned 29-bit identifier convention described in the brief.
package can_filt_pkg;
    localparam int WORD_W = 32;
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int HALF_W = 16;
    localparam int PID_W  = 14;
    localparam int PFX_W  = 8;

    // Bit positions inside a full-ID word
    localparam int FULL_RTR_BIT = 31;
    localparam int FULL_IDE_BIT = 30;

    // Bit positions inside a 16-bit half
    localparam int HALF_RTR_BIT = 15;
    localparam int HALF_IDE_BIT = 14;

    typedef logic [WORD_W-1:0] filt_word_t;
    typedef logic [HALF_W-1:0] filt_half_t;
    typedef logic [ID_W-1:0]   frame_id_t;

    typedef enum logic [1:0] {
        FMT_ONE  = 2'b00,
        FMT_TWO  = 2'b01,
        FMT_FOUR = 2'b10,
        FMT_NONE = 2'b11
    } filt_fmt_e;
endpackage

// File: rtl/can_filt_table.sv
// Module: filter word storage. Holds NUM_ELEM filter words and writes one
// per cycle from the write port. Assumes writes are meaningful only while
// freeze is high; all other writes are dropped. Out-of-range addresses are
// dropped too.
module can_filt_table
    import can_filt_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    localparam int ADDR_W  = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      freeze,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  filt_word_t                wr_data,
    output filt_word_t [NUM_ELEM-1:0] tbl
);

    logic wr_ok;

    // Qualify the write with freeze and the address range
    always_comb begin
        wr_ok = wr_en && freeze && (32'(wr_addr) < NUM_ELEM);
    end

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_word
        // Word storage: clear on reset, load on a qualified write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[e] <= '0;
            end else if (wr_ok && (32'(wr_addr) == e)) begin
                tbl[e] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/can_filt_elem_match.sv
// Module: match logic for one filter word, evaluated in all three formats at
// once. The top selects which result set is used. Assumes standard IDs
// are left-aligned in frame_id[28:18].
module can_filt_elem_match
    import can_filt_pkg::*;
(
    input  filt_word_t word,
    input  frame_id_t  frame_id,
    input  logic       frame_ide,
    input  logic       frame_rtr,
    output logic       hit_one,
    output logic [1:0] hit_two,
    output logic [3:0] hit_four
);

    localparam int STD_LSB = ID_W - STD_W;
    localparam int PID_LSB = ID_W - PID_W;
    localparam int PFX_LSB = ID_W - PFX_W;

    logic one_qual;
    logic one_idm;

    // Full-ID format: qualifiers must agree, then compare 11 or 29 bits
    always_comb begin
        one_qual = (word[FULL_RTR_BIT] == frame_rtr) &&
                   (word[FULL_IDE_BIT] == frame_ide);
        if (frame_ide) begin
            one_idm = (word[ID_W-1:0] == frame_id);
        end else begin
            one_idm = (word[ID_W-1:STD_LSB] == frame_id[ID_W-1:STD_LSB]);
        end
        hit_one = one_qual && one_idm;
    end

    for (genvar s = 0; s < 2; s++) begin : g_half
        localparam int HI = WORD_W - 1 - s * HALF_W;
        filt_half_t half;
        logic       h_qual;
        logic       h_idm;

        // Half-ID format: pick half s, check qualifiers, compare prefix
        always_comb begin
            half   = word[HI -: HALF_W];
            h_qual = (half[HALF_RTR_BIT] == frame_rtr) &&
                     (half[HALF_IDE_BIT] == frame_ide);
            if (frame_ide) begin
                h_idm = (half[PID_W-1:0] == frame_id[ID_W-1:PID_LSB]);
            end else begin
                h_idm = (half[PID_W-1:PID_W-STD_W] == frame_id[ID_W-1:STD_LSB]);
            end
            hit_two[s] = h_qual && h_idm;
        end
    end

    for (genvar s = 0; s < 4; s++) begin : g_byte
        localparam int HI = WORD_W - 1 - s * PFX_W;

        // Prefix format: byte s against the top 8 ID bits, any frame type
        always_comb begin
            hit_four[s] = (word[HI -: PFX_W] == frame_id[ID_W-1:PFX_LSB]);
        end
    end

endmodule

// File: rtl/can_filt_prio.sv
// Module: lowest-index-first priority encoder. Reports whether any bit is
// set and the position of the lowest set bit. Assumes W >= 2.
module can_filt_prio #(
    parameter int W = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit is the last assignment
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_rx_id_filter.sv
// Module: receive identifier acceptance filter top. Compares a strobed
// frame against the filter table in the selected format and registers the
// accept flag and lowest matching sub-entry index one cycle later.
// Assumes frame_vld is a single-cycle strobe and the table is loaded
// under freeze.
module can_rx_id_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    localparam int ADDR_W  = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
    localparam int NUM_SUB = NUM_ELEM * 4,
    localparam int IDX_W   = $clog2(NUM_SUB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        fmt_sel,
    input  logic              frame_vld,
    input  logic [28:0]       frame_id,
    input  logic              frame_ide,
    input  logic              frame_rtr,
    output logic              acc_hit,
    output logic [IDX_W-1:0]  acc_idx
);

    filt_word_t [NUM_ELEM-1:0] filt_tbl;
    logic [NUM_ELEM-1:0]       one_hit;
    logic [2*NUM_ELEM-1:0]     two_hit;
    logic [NUM_SUB-1:0]        four_hit;
    logic [NUM_SUB-1:0]        sel_hit;
    logic                      any_hit;
    logic [IDX_W-1:0]          first_idx;
    filt_fmt_e                 fmt;

    can_filt_table #(.NUM_ELEM(NUM_ELEM)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .freeze  (freeze),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tbl     (filt_tbl)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        can_filt_elem_match i_match (
            .word      (filt_tbl[e]),
            .frame_id  (frame_id),
            .frame_ide (frame_ide),
            .frame_rtr (frame_rtr),
            .hit_one   (one_hit[e]),
            .hit_two   (two_hit[2*e +: 2]),
            .hit_four  (four_hit[4*e +: 4])
        );
    end

    // Choose the hit vector of the active format, numbered as sub-entries
    always_comb begin
        fmt = filt_fmt_e'(fmt_sel);
        unique case (fmt)
            FMT_ONE:  sel_hit = NUM_SUB'(one_hit);
            FMT_TWO:  sel_hit = NUM_SUB'(two_hit);
            FMT_FOUR: sel_hit = four_hit;
            default:  sel_hit = '0;
        endcase
    end

    can_filt_prio #(.W(NUM_SUB)) i_prio (
        .vec (sel_hit),
        .any (any_hit),
        .idx (first_idx)
    );

    // Result register: a pulse one cycle after the strobe, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hit <= 1'b0;
            acc_idx <= '0;
        end else begin
            acc_hit <= frame_vld && any_hit;
            acc_idx <= (frame_vld && any_hit) ? first_idx : '0;
        end
    end

endmodule

// File: rtl/can_filt_chk.sv
// Module: assertion checker for the acceptance filter, bound to the top.
// Assumes the standard layout of the filter word given in the brief.
module can_filt_chk #(
    parameter int NUM_ELEM = 8,
    localparam int IDX_W   = $clog2(NUM_ELEM * 4)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     freeze,
    input logic [1:0]               fmt_sel,
    input logic                     frame_vld,
    input logic [28:0]              frame_id,
    input logic                     frame_ide,
    input logic                     frame_rtr,
    input logic                     acc_hit,
    input logic [IDX_W-1:0]         acc_idx,
    input logic [NUM_ELEM-1:0][31:0] tbl
);

    assert_idle_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> (!acc_hit && acc_idx == '0));

    assert_reject_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && fmt_sel == 2'b11) |=> !acc_hit);

    assert_frozen_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> $stable(tbl));

    assert_one_id_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && fmt_sel == 2'b00) |=> (32'(acc_idx) < NUM_ELEM));

    assert_first_std_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && fmt_sel == 2'b00 && !frame_ide &&
         tbl[0][31] == frame_rtr && !tbl[0][30] &&
         tbl[0][28:18] == frame_id[28:18]) |=> (acc_hit && acc_idx == '0));

    assert_first_prefix_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && fmt_sel == 2'b10 && tbl[0][31:24] == frame_id[28:21])
        |=> (acc_hit && acc_idx == '0));

endmodule

bind can_rx_id_filter can_filt_chk #(.NUM_ELEM(NUM_ELEM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .fmt_sel   (fmt_sel),
    .frame_vld (frame_vld),
    .frame_id  (frame_id),
    .frame_ide (frame_ide),
    .frame_rtr (frame_rtr),
    .acc_hit   (acc_hit),
    .acc_idx   (acc_idx),
    .tbl       (filt_tbl)
);

// File: tb/test_can_rx_id_filter.sv
module test_can_rx_id_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        frame_vld = 1'b0;
    logic [28:0] frame_id = '0;
    logic        frame_ide = 1'b0;
    logic        frame_rtr = 1'b0;
    logic        acc_hit;
    logic [4:0]  acc_idx;

    logic [31:0] sh [NE];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_rx_id_filter i_can_rx_id_filter (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .fmt_sel(fmt_sel),
        .frame_vld(frame_vld), .frame_id(frame_id), .frame_ide(frame_ide),
        .frame_rtr(frame_rtr), .acc_hit(acc_hit), .acc_idx(acc_idx)
    );

    function automatic logic [31:0] mix(input int a);
        logic [31:0] x;
        x = 32'(a) * 32'h9E3779B1;
        x = x ^ (x >> 15);
        x = x * 32'h85EBCA6B;
        x = x ^ (x >> 13);
        return x;
    endfunction

    // Expected result from the requirements: lowest matching sub-entry
    function automatic logic [5:0] model(input logic [1:0] f, input logic [28:0] id,
                                         input logic ide, input logic rtr);
        for (int k = 0; k < NE; k++) begin
            logic [31:0] w = sh[k];
            if (f == 2'b00) begin
                if (w[31] == rtr && w[30] == ide &&
                    (ide ? (w[28:0] == id) : (w[28:18] == id[28:18])))
                    return {1'b1, 5'(k)};
            end else if (f == 2'b01) begin
                for (int s = 0; s < 2; s++) begin
                    logic [15:0] h = (s == 0) ? w[31:16] : w[15:0];
                    if (h[15] == rtr && h[14] == ide &&
                        (ide ? (h[13:0] == id[28:15]) : (h[13:3] == id[28:18])))
                        return {1'b1, 5'(2*k + s)};
                end
            end else if (f == 2'b10) begin
                for (int s = 0; s < 4; s++) begin
                    if (w[31-8*s -: 8] == id[28:21])
                        return {1'b1, 5'(4*k + s)};
                end
            end
        end
        return 6'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        if (freeze) sh[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                        input string req);
        logic [5:0] e;
        e = model(fmt_sel, id, ide, rtr);
        @(negedge clk);
        frame_id = id; frame_ide = ide; frame_rtr = rtr; frame_vld = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0;
        chk({acc_hit, acc_idx} == e, req, 32'({acc_hit, acc_idx}), 32'(e));
        @(negedge clk);
        chk({acc_hit, acc_idx} == 6'd0, "R10", 32'({acc_hit, acc_idx}), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) sh[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state of the outputs
        chk({acc_hit, acc_idx} == 6'd0, "R10", 32'({acc_hit, acc_idx}), 32'd0);
        rst_n = 1'b1;

        // Sweep: every format, several tables, every sub-entry, four variants
        for (int f = 0; f < 4; f++) begin
            fmt_sel = 2'(f);
            for (int seed = 0; seed < 3; seed++) begin
                freeze = 1'b1;
                for (int e = 0; e < NE; e++) wr(e, mix(seed*77 + e + f*500));
                freeze = 1'b0;
                // R9: unfrozen writes must be dropped
                for (int e = 0; e < NE; e++) wr(e, ~mix(seed*91 + e));
                for (int e = 0; e < NE; e++) begin
                    int subs = (f == 1) ? 2 : ((f == 2) ? 4 : 1);
                    for (int s = 0; s < subs; s++) begin
                        for (int v = 0; v < 4; v++) begin
                            logic [31:0] w = sh[e];
                            logic [31:0] r = mix(seed*1000 + e*16 + s*4 + v + f*7777);
                            logic [15:0] h = s[0] ? w[15:0] : w[31:16];
                            logic [28:0] id;
                            logic ide, rtr;
                            string req;
                            case (f)
                                0: begin id = w[28:0]; ide = w[30]; rtr = w[31]; end
                                1: begin
                                    ide = h[14]; rtr = h[15];
                                    id = ide ? {h[13:0], r[14:0]} : {h[13:3], r[17:0]};
                                end
                                2: begin id = {w[31-8*s -: 8], r[20:0]}; ide = r[22]; rtr = r[23]; end
                                default: begin id = w[28:0]; ide = r[0]; rtr = r[1]; end
                            endcase
                            if (v == 1) ide = ~ide;
                            if (v == 2) rtr = ~rtr;
                            if (v == 3) id[32'(r[27:23]) % 29] = ~id[32'(r[27:23]) % 29];
                            case (f)
                                0: req = (v == 1 || v == 2) ? "R3" : (ide ? "R2" : "R1");
                                1: req = (v == 1 || v == 2) ? "R3" : (ide ? "R5" : "R4");
                                2: req = "R6";
                                default: req = "R7";
                            endcase
                            send(id, ide, rtr, req);
                        end
                    end
                end
            end
        end

        // R8: duplicate full-ID words, lowest element wins
        fmt_sel = 2'b00;
        freeze = 1'b1;
        for (int e = 0; e < NE; e++) wr(e, 32'h0000_0000 | (32'(e + 1) << 18));
        wr(3, 32'h4ABC_DE12);
        wr(6, 32'h4ABC_DE12);
        send(29'h0ABC_DE12, 1'b1, 1'b0, "R8");
        chk(model(2'b00, 29'h0ABC_DE12, 1'b1, 1'b0) == {1'b1, 5'd3}, "R8", 32'd0, 32'd3);

        // R8: duplicate bytes inside one word and across words, prefix format
        fmt_sel = 2'b10;
        wr(1, 32'h5A5A_5A5A);
        wr(2, 32'h005A_0000);
        send({8'h5A, 21'h1F0F0}, 1'b0, 1'b1, "R8");

        // R8: two-ID format, matching second half of element 0 and first of 4
        fmt_sel = 2'b01;
        wr(0, {16'h0000, 2'b01, 14'h1234});
        wr(4, {2'b01, 14'h1234, 16'h0000});
        send({14'h1234, 15'h7ABC}, 1'b1, 1'b0, "R8");

        // R9: a write without freeze leaves element 0 intact
        fmt_sel = 2'b00;
        wr(0, 32'h0123_4567 & 32'h3FFF_FFFF);
        freeze = 1'b0;
        wr(0, 32'hFFFF_FFFF);
        send(29'h0123_4567 & 29'h1FFC_0000, 1'b0, 1'b0, "R9");

        // R1: standard frame ignores the low 18 ID bits
        send(29'h0123_4567 | 29'h0003_FFFF, 1'b0, 1'b0, "R1");

        // R7: reject-all mode with a table that would otherwise match
        fmt_sel = 2'b11;
        send(29'h0123_4567 & 29'h1FFC_0000, 1'b0, 1'b0, "R7");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule